// File: doc/BRIEF.md
# Prescaled Bit-Reset PWM Generator

A single-channel pulse-width modulator driven by a slow clock-enable tick (nominally 32 kHz) and configured through two byte-wide registers on a simple synchronous register bus. One free-running 8-bit counter advances on each tick. A 2-bit prescaler chooses which counter bit acts as the wrap trigger. As soon as that bit would become set, the counter returns to zero. This gives periods of 128, 64, 32 or 16 ticks. The counter bits below the trigger bit are compared against a 7-bit duty value to form the output.

Prescaler and duty changes act at once. The counter is not cleared and no value is shadowed. The quirks that follow from this are part of the behaviour:
- A prescaler change in mid-period lets a stale high count run on until the new trigger bit sets.
- A duty value above the period holds the output high.
- The longest period can never reach a fully high output.

Software writes the duty value first when shortening the period, and the prescaler first when lengthening it.

Top module: `pwm_bitreset`

## Requirements
- R1: After a synchronous reset, both registers read 0x00 and `pwm_out` is low.
- R2: Address 0 is the control register: bit 7 is enable and bits [1:0] are the prescaler p. All other bits read 0. Address 1 is the duty register, with bits [6:0] significant and bit 7 reading 0. `bus_rdata` shows the addressed register one clock after the address is presented. Addresses 2 and 3 read 0x00 and writes to them change nothing.
- R3: The counter advances only on clocks where `tick` is high. With `tick` low, the output holds its value.
- R4: With prescaler p, the output period is 128 >> p ticks. In steady state, rising edges of `pwm_out` are that many ticks apart.
- R5: The output is high while the counter bits below the trigger bit (bits [6-p:0]) are strictly less than the duty value. A duty value of 0 keeps the output low.
- R6: With p = 0 and duty 127, the output is low for exactly one tick in every 128. With p ≥ 1 and duty equal to the period (for example 64 at p = 1), the output is always high.
- R7: A duty value greater than the current period keeps the output high for the whole period.
- R8: Writing a new prescaler does not clear the counter. A count above the new period keeps incrementing until trigger bit 7-p would become set, and then wraps to 0.
- R9: A duty write takes effect at the next compare. `pwm_out` reflects the new value one clock after the write, without waiting for a period boundary.
- R10: While enable is 0, `pwm_out` is low and the counter is held at zero. After re-enabling, counting starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable (32 kHz rate) |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The checker checks these on every clock:
- the disabled state holds the output low and the counter at zero;
- each tick either increments the counter or wraps it to zero, and no tick leaves it unchanged;
- a zero duty forces the output low;
- a duty at or above the period forces it high;
- the p = 0 terminal count drives it low;
- a duty write lands in the duty register.

Only the bench scenarios can show whole-period properties:
- the exact period for each prescaler and the high-time per period;
- the one low tick in 128 at p = 0;
- the stale-count wrap after a mid-period prescaler change;
- that a duty change is visible before the period ends.

// File: rtl/pwm_bitreset_pkg.sv
package pwm_bitreset_pkg;
  localparam int DEF_CNT_W  = 8;
  localparam int DEF_PSC_W  = 2;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ADDR_W = 2;
  // register addresses and control field positions decoded by software
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DUTY  = 1;
  localparam int EN_BIT     = 7;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bitreset_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int PSC_W  = DEF_PSC_W,
  parameter int DUTY_W = DEF_DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en,
  output logic [PSC_W-1:0]  psc,
  output logic [DUTY_W-1:0] duty
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADDR_DUTY);

  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] duty_view;
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      psc  <= '0;
      duty <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) begin
        en  <= bus_wdata[EN_BIT];
        psc <= bus_wdata[PSC_W-1:0];
      end else if (bus_addr == A_DUTY) begin
        duty <= bus_wdata[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[EN_BIT] = en;
    ctrl_view[PSC_W-1:0] = psc;
    duty_view = '0;
    duty_view[DUTY_W-1:0] = duty;
    if (bus_addr == A_CTRL)      rd_next = ctrl_view;
    else if (bus_addr == A_DUTY) rd_next = duty_view;
    else                         rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_bitreset_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int PSC_W = DEF_PSC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] cnt
);
  localparam int PSC_N = 1 << PSC_W;

  logic [CNT_W-1:0] trig_tbl [PSC_N];
  logic [CNT_W-1:0] inc;
  logic             wrap;

  // one trigger bit per prescaler setting: bit CNT_W-1-p
  for (genvar gi = 0; gi < PSC_N; gi++) begin : g_trig
    assign trig_tbl[gi] = {{(CNT_W-1){1'b0}}, 1'b1} << (CNT_W - 1 - gi);
  end

  always_comb begin
    inc  = cnt + 1'b1;
    wrap = |(inc & trig_tbl[psc]);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= wrap ? '0 : inc;
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_bitreset_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int PSC_W  = DEF_PSC_W,
  parameter int DUTY_W = DEF_CNT_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSC_W-1:0]  psc,
  input  logic [DUTY_W-1:0] duty,
  input  logic [CNT_W-1:0]  cnt,
  output logic              pwm_out
);
  localparam int PSC_N = 1 << PSC_W;

  logic [CNT_W-1:0] mask_tbl [PSC_N];
  logic [CNT_W-1:0] low_bits;
  logic [CNT_W-1:0] duty_ext;
  logic             hit;

  // period-count bits below the trigger bit for each prescaler
  for (genvar gi = 0; gi < PSC_N; gi++) begin : g_mask
    assign mask_tbl[gi] = {CNT_W{1'b1}} >> (gi + 1);
  end

  always_comb begin
    low_bits = cnt & mask_tbl[psc];
    duty_ext = {{(CNT_W-DUTY_W){1'b0}}, duty};
    hit      = duty_ext > low_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en && hit;
  end
endmodule

// File: rtl/pwm_bitreset.sv
module pwm_bitreset
  import pwm_bitreset_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int PSC_W  = DEF_PSC_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int DUTY_W = CNT_W - 1;

  logic              en_w;
  logic [PSC_W-1:0]  psc_w;
  logic [DUTY_W-1:0] duty_w;
  logic [CNT_W-1:0]  cnt_w;

  pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en(en_w), .psc(psc_w), .duty(duty_w)
  );

  pwm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_w), .tick(tick), .psc(psc_w), .cnt(cnt_w)
  );

  pwm_compare #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst(rst), .en(en_w), .psc(psc_w), .duty(duty_w),
    .cnt(cnt_w), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_bitreset_chk.sv
module pwm_bitreset_chk #(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              en,
  input logic [PSC_W-1:0]  psc,
  input logic [CNT_W-2:0]  duty,
  input logic [CNT_W-1:0]  cnt,
  input logic              pwm_out,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  logic [CNT_W-1:0] period_len;
  logic [CNT_W-1:0] duty_ext;
  assign period_len = {{(CNT_W-1){1'b0}}, 1'b1} << (CNT_W - 1 - int'(psc));
  assign duty_ext   = {1'b0, duty};

  // R10
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);
  // R10
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> ((cnt == '0) || (cnt == $past(cnt) + 1'b1)));
  // R5
  duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> !pwm_out);
  // R7
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (duty_ext >= period_len)) |=> pwm_out);
  // R6
  no_full_p0_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (psc == '0) && (cnt[CNT_W-2:0] == {(CNT_W-1){1'b1}})) |=> !pwm_out);
  // R2
  duty_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == ADDR_W'(1))) |=> (duty == $past(bus_wdata[CNT_W-2:0])));
endmodule

bind pwm_bitreset pwm_bitreset_chk #(
  .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .en(en_w), .psc(psc_w), .duty(duty_w),
  .cnt(cnt_w), .pwm_out(pwm_out), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/tb_pwm_bitreset.sv
`timescale 1ns/1ps
module tb_pwm_bitreset;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_bitreset dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // one tick pulse; returns after the registered output has followed
  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] p, input logic [6:0] d);
    tick = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, {1'b0, d});
    wr(2'd0, {6'b100000, p});
    @(negedge clk);
  endtask

  // clocks between two rising edges, and high clocks within that span
  task automatic measure(output int per, output int hi);
    int guard;
    logic prev;
    per = 0; hi = 0; guard = 0;
    prev = pwm_out;
    while (!(pwm_out && !prev) && guard < 1000) begin
      prev = pwm_out; @(negedge clk); guard++;
    end
    prev = pwm_out;
    do begin
      if (pwm_out) hi++;
      per++;
      prev = pwm_out; @(negedge clk);
    end while (!(pwm_out && !prev) && per < 1000);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(pwm_out == 1'b0, "R1 out", int'(pwm_out), 0);
    rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd1, v); check(v == 8'h00, "R1 duty", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check(v == 8'h83, "R2 ctrl unused bits", v, 8'h83);
    wr(2'd1, 8'hFF); rd(2'd1, v); check(v == 8'h7F, "R2 duty bit7", v, 8'h7F);
    wr(2'd2, 8'hAA); rd(2'd2, v); check(v == 8'h00, "R2 addr2", v, 0);
    wr(2'd3, 8'h00); rd(2'd0, v); check(v == 8'h83, "R2 addr3 write ignored", v, 8'h83);
    rd(2'd1, v); check(v == 8'h7F, "R2 duty kept", v, 8'h7F);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_period(input int p);
    int per, hi, plen, d;
    plen = 128 >> p;
    d = plen / 4 + 1;
    setup(2'(p), 7'(d));
    tick = 1'b1;
    measure(per, hi);
    tick = 1'b0;
    check(per == plen, "R4 period", per, plen);
    check(hi == d, "R5 high time", hi, d);
  endtask

  task automatic t_duty_zero();
    int hi = 0;
    setup(2'd2, 7'd0);
    tick = 1'b1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (pwm_out) hi++; end
    tick = 1'b0;
    check(hi == 0, "R5 duty zero", hi, 0);
  endtask

  task automatic t_full();
    int lo = 0;
    setup(2'd0, 7'd127);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 256; i++) begin @(negedge clk); if (!pwm_out) lo++; end
    check(lo == 2, "R6 p0 low ticks in 256", lo, 2);
    tick = 1'b0;
    lo = 0;
    setup(2'd1, 7'd64);
    tick = 1'b1;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!pwm_out) lo++; end
    check(lo == 0, "R6 p1 duty 64", lo, 0);
    tick = 1'b0;
  endtask

  task automatic t_over();
    int lo = 0;
    setup(2'd3, 7'd100);
    tick = 1'b1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!pwm_out) lo++; end
    tick = 1'b0;
    check(lo == 0, "R7 duty above period", lo, 0);
  endtask

  task automatic t_glitch();
    int c, e;
    setup(2'd0, 7'd8);
    for (int i = 0; i < 100; i++) tick_once();
    wr(2'd0, 8'h83);
    @(negedge clk);
    check(pwm_out == 1'b1, "R8 stale count 100 low bits 4", int'(pwm_out), 1);
    for (int k = 1; k <= 16; k++) begin
      tick_once();
      c = (k < 12) ? 100 + k : k - 12;
      e = ((c & 15) < 8) ? 1 : 0;
      check(int'(pwm_out) == e, "R8 no clear on prescaler write", int'(pwm_out), e);
    end
  endtask

  task automatic t_duty_now();
    setup(2'd3, 7'd10);
    for (int i = 0; i < 5; i++) tick_once();
    check(pwm_out == 1'b1, "R9 before", int'(pwm_out), 1);
    wr(2'd1, 8'd3); @(negedge clk);
    check(pwm_out == 1'b0, "R9 lower duty at once", int'(pwm_out), 0);
    wr(2'd1, 8'd6); @(negedge clk);
    check(pwm_out == 1'b1, "R9 raise duty at once", int'(pwm_out), 1);
  endtask

  task automatic t_tick_gate();
    int per, hi;
    logic held;
    held = pwm_out;
    repeat (50) @(negedge clk);
    check(pwm_out == held, "R3 hold without tick", int'(pwm_out), int'(held));
    setup(2'd3, 7'd8);
    fork
      begin
        while (!done) begin
          @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
          @(negedge clk);
        end
      end
      begin measure(per, hi); done = 1; end
    join
    done = 0;
    tick = 1'b0;
    check(per == 48, "R3 period at tick every 3 clocks", per, 48);
  endtask

  task automatic t_disable();
    int hi = 0;
    setup(2'd3, 7'd5);
    tick = 1'b1;
    repeat (7) @(negedge clk);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out) hi++; end
    check(hi == 0, "R10 disabled low", hi, 0);
    tick = 1'b0;
    wr(2'd0, 8'h83);
    @(negedge clk);
    for (int i = 0; i < 4; i++) tick_once();
    check(pwm_out == 1'b1, "R10 restart count 4", int'(pwm_out), 1);
    tick_once();
    check(pwm_out == 1'b0, "R10 restart count 5", int'(pwm_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    for (int p = 0; p < 4; p++) t_period(p);
    t_duty_zero();
    t_full();
    t_over();
    t_glitch();
    t_duty_now();
    t_tick_gate();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule